// File: doc/BRIEF.md
# Prioritized Level-Sensitive Interrupt Controller

This block collects up to 128 level-sensitive interrupt sources (96 by default), organised as banks of 32, and presents a single interrupt request line to a processor. Each source has its own 6-bit priority; each bank has a mask register that software can write directly or change bit by bit through separate set and clear addresses. A pending view per bank shows which sources are asserted and not masked.

When at least one source is eligible, a sorting engine locks onto the best candidate and watches it for a fixed window of cycles. If the candidate stays eligible for the whole window, the request line rises and the winner's number can be read from the active-source register. It stays frozen until software writes the acknowledge bit, after which a new sort may begin. If the candidate drops out during the window, because its level fell or it became masked, the sort ends with a spurious result and no request. A revision register, a soft reset with a completion flag and a few held configuration bits complete the register set, which is reached through a simple synchronous bus with one cycle of read latency.

Top module: `intc_ctrl`

## Requirements
- R1: After reset the revision register (0x000) reads 0x10, every bank mask reads 0xFFFFFFFF, the threshold (0x068) reads 0xFF, the active-source register (0x040) reads 0xFFFFFF80, the status register (0x014) reads 1 and `irq` is low.
- R2: The mask of bank b is at 0x084 + 0x20*b and is directly readable and writable. Writing 1 bits to 0x088 + 0x20*b unmasks those sources, writing 1 bits to 0x08C + 0x20*b masks them, and 0 bits in either alias leave the mask unchanged.
- R3: The pending register at 0x098 + 0x20*b reads, for each source of bank b, 1 when the source is asserted and unmasked.
- R4: When the engine is idle and a source is eligible at a clock edge, `irq` is low through the next SORT_CYC edges and rises after edge SORT_CYC+1, counting that edge as the first (10 cycles by default).
- R5: A source's priority is bits 7:2 of the register at 0x100 + 4*n and reads back there. The winner is the eligible source with the lowest priority value, with ties going to the lower source number. While `irq` is high the active-source register holds the winner in bits 6:0 with bits 31:7 zero.
- R6: A source whose priority is not below the threshold value is not eligible, unless the threshold is 0xFF.
- R7: If the locked candidate stops being eligible at any edge of the sort window, `irq` stays low and the active-source register reads bits 31:7 all ones with the abandoned source's number in bits 6:0.
- R8: Once raised, `irq` and the active-source value stay unchanged, even if the winner's level falls. A write of 1 in bit 0 of the control register (0x048) lowers `irq` at that edge, and a new sort starts on the next edge if any source is eligible.
- R9: A control write with bit 0 clear has no effect on `irq` or on the active-source value.
- R10: Writing 1 to bit 1 of the configuration register (0x010) resets every register to its reset value on the following edge. The status register bit 0 reads 0 during that one cycle and 1 afterwards. Bit 0 of the configuration register (automatic idle enable) is read/write and clears on soft reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Functional clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe; data returns on the next cycle |
| addr | input | 12 | Byte address, word aligned |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, registered |
| src | input | NUM_SRC | Level-sensitive interrupt source inputs |
| irq | output | 1 | Interrupt request to the processor |

## Verification
The properties assume that the source levels are synchronous to `clk` and that the bus presents at most one word-aligned access per cycle. They also assume that the acknowledge bit is only written by a control write to 0x048, so that `irq` can fall only through an acknowledge or a soft reset. The stimulus changes every input at the falling edge, issues one access at a time and keeps every address inside the map. Mask and level changes meant to spoil a sort are placed strictly inside the sort window, so that the expected spurious or valid outcome follows from the edge count alone.

// File: rtl/intc_pkg.sv
`timescale 1ns/1ps
package intc_pkg;
    localparam int ADDR_W = 12;
    localparam int DATA_W = 32;
    localparam int BANK_W = 32;
    localparam int ID_W   = 7;
    localparam int PRIO_W = 6;

    localparam logic [ADDR_W-1:0] OFS_REV       = 12'h000;
    localparam logic [ADDR_W-1:0] OFS_SYSCFG    = 12'h010;
    localparam logic [ADDR_W-1:0] OFS_SYSSTAT   = 12'h014;
    localparam logic [ADDR_W-1:0] OFS_ACTIVE    = 12'h040;
    localparam logic [ADDR_W-1:0] OFS_CTRL      = 12'h048;
    localparam logic [ADDR_W-1:0] OFS_PROT      = 12'h04C;
    localparam logic [ADDR_W-1:0] OFS_IDLE      = 12'h050;
    localparam logic [ADDR_W-1:0] OFS_THRESH    = 12'h068;
    localparam logic [ADDR_W-1:0] OFS_PRIO_BASE = 12'h100;

    // offsets inside one 0x20-byte bank window starting at 0x080
    localparam logic [4:0] BK_MASK = 5'h04;
    localparam logic [4:0] BK_CLR  = 5'h08;
    localparam logic [4:0] BK_SET  = 5'h0C;
    localparam logic [4:0] BK_PEND = 5'h18;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_SORT = 2'd1,
        ST_HOLD = 2'd2
    } sort_st_e;
endpackage

// File: rtl/intc_regfile.sv
`timescale 1ns/1ps
module intc_regfile
    import intc_pkg::*;
#(
    parameter int         NUM_SRC = 96,
    parameter logic [7:0] REV     = 8'h10
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           wr_en,
    input  logic                           rd_en,
    input  logic [ADDR_W-1:0]              addr,
    input  logic [DATA_W-1:0]              wdata,
    output logic [DATA_W-1:0]              rdata,
    input  logic [NUM_SRC-1:0]             src,
    input  logic [DATA_W-1:0]              act_word,
    output logic [NUM_SRC-1:0]             mask,
    output logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    output logic [7:0]                     thresh,
    output logic                           ack,
    output logic                           srst_busy
);
    localparam int NB = NUM_SRC / BANK_W;
    localparam logic [ADDR_W-1:0] PRIO_END = OFS_PRIO_BASE + ADDR_W'(4 * NUM_SRC);

    typedef struct packed {
        logic [NUM_SRC-1:0]             mask;
        logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
        logic [7:0]                     thresh;
        logic                           autoidle;
        logic [1:0]                     idle;
        logic                           prot;
        logic                           srst;
        logic [DATA_W-1:0]              rdata;
    } rf_t;

    function automatic rf_t rf_reset();
        rf_t r;
        r        = '0;
        r.mask   = '1;
        r.thresh = 8'hFF;
        return r;
    endfunction

    rf_t q, d;

    logic              bank_hit;
    logic [1:0]        bank_sel;
    logic [4:0]        bofs;
    logic              prio_hit;
    logic [ADDR_W-1:0] prio_off;
    logic [DATA_W-1:0] rd_mux;

    always_comb begin
        bank_hit = (addr[ADDR_W-1:7] == (ADDR_W-7)'(1));
        bank_sel = addr[6:5];
        bofs     = addr[4:0];
        prio_hit = (addr >= OFS_PRIO_BASE) && (addr < PRIO_END) && (addr[1:0] == 2'b00);
        prio_off = addr - OFS_PRIO_BASE;
    end

    // read multiplexer
    always_comb begin
        rd_mux = '0;
        case (addr)
            OFS_REV:     rd_mux = {24'b0, REV};
            OFS_SYSCFG:  rd_mux = {31'b0, q.autoidle};
            OFS_SYSSTAT: rd_mux = {31'b0, ~q.srst};
            OFS_ACTIVE:  rd_mux = act_word;
            OFS_PROT:    rd_mux = {31'b0, q.prot};
            OFS_IDLE:    rd_mux = {30'b0, q.idle};
            OFS_THRESH:  rd_mux = {24'b0, q.thresh};
            default:     rd_mux = '0;
        endcase
        for (int b = 0; b < NB; b++) begin
            if (bank_hit && bank_sel == 2'(b)) begin
                if (bofs == BK_MASK) rd_mux = q.mask[b*BANK_W +: BANK_W];
                if (bofs == BK_PEND) rd_mux = src[b*BANK_W +: BANK_W] & ~q.mask[b*BANK_W +: BANK_W];
            end
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (prio_hit && prio_off[ADDR_W-1:2] == (ADDR_W-2)'(i))
                rd_mux = {24'b0, q.prio[i], 2'b00};
        end
    end

    // next state
    always_comb begin
        d      = q;
        d.srst = 1'b0;
        if (wr_en) begin
            case (addr)
                OFS_SYSCFG: begin
                    d.autoidle = wdata[0];
                    d.srst     = wdata[1];
                end
                OFS_PROT:   d.prot   = wdata[0];
                OFS_IDLE:   d.idle   = wdata[1:0];
                OFS_THRESH: d.thresh = wdata[7:0];
                default: ;
            endcase
            for (int b = 0; b < NB; b++) begin
                if (bank_hit && bank_sel == 2'(b)) begin
                    case (bofs)
                        BK_MASK: d.mask[b*BANK_W +: BANK_W] = wdata;
                        BK_CLR:  d.mask[b*BANK_W +: BANK_W] = q.mask[b*BANK_W +: BANK_W] & ~wdata;
                        BK_SET:  d.mask[b*BANK_W +: BANK_W] = q.mask[b*BANK_W +: BANK_W] | wdata;
                        default: ;
                    endcase
                end
            end
            for (int i = 0; i < NUM_SRC; i++) begin
                if (prio_hit && prio_off[ADDR_W-1:2] == (ADDR_W-2)'(i))
                    d.prio[i] = wdata[7:2];
            end
        end
        if (q.srst) d = rf_reset();
        d.rdata = rd_en ? rd_mux : q.rdata;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= rf_reset();
        else        q <= d;
    end

    assign rdata     = q.rdata;
    assign mask      = q.mask;
    assign prio      = q.prio;
    assign thresh    = q.thresh;
    assign srst_busy = q.srst;
    assign ack       = wr_en && (addr == OFS_CTRL) && wdata[0] && !q.srst;
endmodule

// File: rtl/intc_arbiter.sv
`timescale 1ns/1ps
module intc_arbiter
    import intc_pkg::*;
#(
    parameter int NUM_SRC = 96
) (
    input  logic [NUM_SRC-1:0]             src,
    input  logic [NUM_SRC-1:0]             mask,
    input  logic [NUM_SRC-1:0][PRIO_W-1:0] prio,
    input  logic [7:0]                     thresh,
    output logic [NUM_SRC-1:0]             elig,
    output logic                           found,
    output logic [ID_W-1:0]                win_id
);
    logic thr_off;
    assign thr_off = (thresh == 8'hFF);

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_elig
        assign elig[i] = src[i] & ~mask[i] & (thr_off | ({2'b00, prio[i]} < thresh));
    end

    logic [PRIO_W-1:0] best;

    // strict compare keeps the lower index on equal priority
    always_comb begin
        found  = 1'b0;
        best   = '1;
        win_id = '0;
        for (int i = 0; i < NUM_SRC; i++) begin
            if (elig[i] && (!found || prio[i] < best)) begin
                found  = 1'b1;
                best   = prio[i];
                win_id = ID_W'(i);
            end
        end
    end
endmodule

// File: rtl/intc_sorter.sv
`timescale 1ns/1ps
module intc_sorter
    import intc_pkg::*;
#(
    parameter int NUM_SRC  = 96,
    parameter int SORT_CYC = 10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               srst,
    input  logic [NUM_SRC-1:0] elig,
    input  logic               found,
    input  logic [ID_W-1:0]    win_id,
    input  logic               ack,
    output logic               irq,
    output logic               sort_busy,
    output logic [DATA_W-1:0]  act_word
);
    localparam int CNT_W = $clog2(SORT_CYC + 1);

    typedef struct packed {
        sort_st_e         st;
        logic [CNT_W-1:0] cnt;
        logic [ID_W-1:0]  id;
        logic             spur;
    } sort_t;

    localparam sort_t SORT_RST = '{st: ST_IDLE, cnt: '0, id: '0, spur: 1'b1};

    sort_t q, d;
    logic  cand_ok;
    logic  spur_n;

    assign cand_ok = elig[q.id];

    always_comb begin
        d      = q;
        spur_n = q.spur | ~cand_ok;
        case (q.st)
            ST_IDLE: begin
                if (found) begin
                    d.st   = ST_SORT;
                    d.cnt  = CNT_W'(SORT_CYC - 1);
                    d.id   = win_id;
                    d.spur = 1'b0;
                end
            end
            ST_SORT: begin
                d.spur = spur_n;
                if (q.cnt == '0) d.st  = spur_n ? ST_IDLE : ST_HOLD;
                else             d.cnt = q.cnt - 1'b1;
            end
            ST_HOLD: begin
                if (ack) begin
                    d.st   = ST_IDLE;
                    d.spur = 1'b1;
                end
            end
            default: d = SORT_RST;
        endcase
        if (srst) d = SORT_RST;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= SORT_RST;
        else        q <= d;
    end

    assign irq       = (q.st == ST_HOLD);
    assign sort_busy = (q.st == ST_SORT);
    assign act_word  = (q.st == ST_HOLD) ? {{(DATA_W-ID_W){1'b0}}, q.id}
                                         : {{(DATA_W-ID_W){1'b1}}, q.id};
endmodule

// File: rtl/intc_ctrl.sv
`timescale 1ns/1ps
module intc_ctrl
    import intc_pkg::*;
#(
    parameter int         NUM_SRC  = 96,
    parameter int         SORT_CYC = 10,
    parameter logic [7:0] REV      = 8'h10
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic               rd_en,
    input  logic [ADDR_W-1:0]  addr,
    input  logic [DATA_W-1:0]  wdata,
    output logic [DATA_W-1:0]  rdata,
    input  logic [NUM_SRC-1:0] src,
    output logic               irq
);
    logic [NUM_SRC-1:0]             mask;
    logic [NUM_SRC-1:0][PRIO_W-1:0] prio;
    logic [7:0]                     thresh;
    logic                           ack;
    logic                           srst_busy;
    logic [NUM_SRC-1:0]             elig;
    logic                           found;
    logic [ID_W-1:0]                win_id;
    logic                           sort_busy;
    logic [DATA_W-1:0]              act_word;

    intc_regfile #(.NUM_SRC(NUM_SRC), .REV(REV)) u_regs (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .rd_en     (rd_en),
        .addr      (addr),
        .wdata     (wdata),
        .rdata     (rdata),
        .src       (src),
        .act_word  (act_word),
        .mask      (mask),
        .prio      (prio),
        .thresh    (thresh),
        .ack       (ack),
        .srst_busy (srst_busy)
    );

    intc_arbiter #(.NUM_SRC(NUM_SRC)) u_arb (
        .src    (src),
        .mask   (mask),
        .prio   (prio),
        .thresh (thresh),
        .elig   (elig),
        .found  (found),
        .win_id (win_id)
    );

    intc_sorter #(.NUM_SRC(NUM_SRC), .SORT_CYC(SORT_CYC)) u_sort (
        .clk       (clk),
        .rst_n     (rst_n),
        .srst      (srst_busy),
        .elig      (elig),
        .found     (found),
        .win_id    (win_id),
        .ack       (ack),
        .irq       (irq),
        .sort_busy (sort_busy),
        .act_word  (act_word)
    );
endmodule

// File: rtl/intc_ctrl_chk.sv
`timescale 1ns/1ps
module intc_ctrl_chk
    import intc_pkg::*;
#(
    parameter int SORT_CYC = 10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_en,
    input logic [ADDR_W-1:0] addr,
    input logic [DATA_W-1:0] wdata,
    input logic              irq,
    input logic              sort_busy,
    input logic              srst_busy,
    input logic [DATA_W-1:0] act_word
);
    logic        ack_wr;
    logic [15:0] run_q;

    assign ack_wr = wr_en && (addr == OFS_CTRL) && wdata[0];

    // length of the current unbroken sorting stretch
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)         run_q <= '0;
        else if (sort_busy) run_q <= run_q + 16'd1;
        else                run_q <= '0;
    end

    p_sort_window_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> run_q == 16'(SORT_CYC));

    p_winner_word_r5: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> act_word[DATA_W-1:ID_W] == '0);

    p_irq_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && !ack_wr && !srst_busy |=> irq);

    p_irq_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && ack_wr && !srst_busy |=> !irq);

    p_result_frozen_r8: assert property (@(posedge clk) disable iff (!rst_n)
        irq && $past(irq) |-> $stable(act_word));

    p_soft_reset_r10: assert property (@(posedge clk) disable iff (!rst_n)
        srst_busy |=> !irq && !srst_busy);
endmodule

bind intc_ctrl intc_ctrl_chk #(.SORT_CYC(SORT_CYC)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .wdata     (wdata),
    .irq       (irq),
    .sort_busy (sort_busy),
    .srst_busy (srst_busy),
    .act_word  (act_word)
);

// File: tb/tb_intc_ctrl.sv
`timescale 1ns/1ps
module tb_intc_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int NSRC       = 96;
    localparam int SORT_N     = 10;
    localparam int WD_LIMIT   = 20000;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             wr_en = 1'b0;
    logic             rd_en = 1'b0;
    logic [11:0]      addr = '0;
    logic [31:0]      wdata = '0;
    logic [31:0]      rdata;
    logic [NSRC-1:0]  src = '0;
    logic             irq;

    int n_chk  = 0;
    int n_fail = 0;
    int cyc    = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    logic rd_flag = 1'b0;

    intc_ctrl #(.NUM_SRC(NSRC), .SORT_CYC(SORT_N)) dut (
        .clk   (clk),
        .rst_n (rst_n),
        .wr_en (wr_en),
        .rd_en (rd_en),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata),
        .src   (src),
        .irq   (irq)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    always @(posedge clk) begin
        cyc++;
        if (cyc == WD_LIMIT) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual cycle %0d expected completion before %0d", cyc, WD_LIMIT);
            $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    // monitor: compares each returned read against the queued expectation
    always @(posedge clk) rd_flag <= rd_en;
    always @(negedge clk) begin
        if (rd_flag) begin
            exp_t e;
            e = sb_q.pop_front();
            n_chk++;
            if (rdata !== e.exp) begin
                n_fail++;
                $display("FAIL %s: read actual 0x%08h expected 0x%08h", e.tag, rdata, e.exp);
            end
        end
    end

    task automatic wr(input logic [11:0] a, input logic [31:0] v);
        wr_en = 1'b1; addr = a; wdata = v;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [11:0] a, input logic [31:0] v, input string tag);
        exp_t e;
        e.exp = v; e.tag = tag;
        sb_q.push_back(e);
        rd_en = 1'b1; addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic chk_irq(input logic v, input string tag);
        n_chk++;
        if (irq !== v) begin
            n_fail++;
            $display("FAIL %s: irq actual %0b expected %0b", tag, irq, v);
        end
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_irq(input int lim);
        for (int k = 0; k < lim; k++) begin
            if (irq === 1'b1) break;
            @(negedge clk);
        end
    endtask

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(1);

        // R1: reset state
        chk_irq(1'b0, "R1");
        rd(12'h000, 32'h0000_0010, "R1");
        rd(12'h084, 32'hFFFF_FFFF, "R1");
        rd(12'h0A4, 32'hFFFF_FFFF, "R1");
        rd(12'h0C4, 32'hFFFF_FFFF, "R1");
        rd(12'h068, 32'h0000_00FF, "R1");
        rd(12'h040, 32'hFFFF_FF80, "R1");
        rd(12'h014, 32'h0000_0001, "R1");

        // R2: mask aliases and direct access
        wr(12'h088, 32'h0000_00F0);
        rd(12'h084, 32'hFFFF_FF0F, "R2");
        wr(12'h08C, 32'h0000_0010);
        rd(12'h084, 32'hFFFF_FF1F, "R2");
        wr(12'h08C, 32'h0000_0000);
        wr(12'h088, 32'h0000_0000);
        rd(12'h084, 32'hFFFF_FF1F, "R2");
        wr(12'h0A4, 32'h1234_5678);
        rd(12'h0A4, 32'h1234_5678, "R2");

        // R3: pending per bank
        src[4] = 1'b1; src[5] = 1'b1; src[40] = 1'b1;
        rd(12'h098, 32'h0000_0020, "R3");
        rd(12'h0B8, 32'h0000_0100, "R3");
        src = '0;
        wr(12'h0A4, 32'hFFFF_FFFF);
        wr(12'h08C, 32'hFFFF_FFFF);
        idle(15);
        wr(12'h048, 32'h1);
        idle(2);
        chk_irq(1'b0, "R3");

        // R5: priorities, R4: latency
        wr(12'h11C, 32'h0000_000C);
        wr(12'h124, 32'h0000_0004);
        wr(12'h130, 32'h0000_0004);
        rd(12'h124, 32'h0000_0004, "R5");
        wr(12'h088, 32'h0000_1280);
        src[7] = 1'b1; src[9] = 1'b1; src[12] = 1'b1;
        for (int k = 1; k <= SORT_N + 1; k++) begin
            @(negedge clk);
            if (k == SORT_N)     chk_irq(1'b0, "R4");
            if (k == SORT_N + 1) chk_irq(1'b1, "R4");
        end
        rd(12'h040, 32'h0000_0009, "R5");

        // R8: frozen result, R9: zero control write
        src[9] = 1'b0;
        idle(3);
        chk_irq(1'b1, "R8");
        rd(12'h040, 32'h0000_0009, "R8");
        wr(12'h048, 32'h0);
        idle(2);
        chk_irq(1'b1, "R9");
        rd(12'h040, 32'h0000_0009, "R9");
        wr(12'h048, 32'h1);
        chk_irq(1'b0, "R8");
        wait_irq(20);
        chk_irq(1'b1, "R8");
        rd(12'h040, 32'h0000_000C, "R5");

        // R6: threshold
        wr(12'h068, 32'h0000_0002);
        src[12] = 1'b0;
        wr(12'h048, 32'h1);
        idle(25);
        chk_irq(1'b0, "R6");
        wr(12'h068, 32'h0000_00FF);
        wait_irq(20);
        chk_irq(1'b1, "R6");
        rd(12'h040, 32'h0000_0007, "R6");
        src[7] = 1'b0;
        wr(12'h048, 32'h1);
        idle(2);
        chk_irq(1'b0, "R8");

        // R7: level falls inside the window
        src[7] = 1'b1;
        idle(4);
        src[7] = 1'b0;
        idle(15);
        chk_irq(1'b0, "R7");
        rd(12'h040, 32'hFFFF_FF87, "R7");
        // R7: mask change inside the window
        src[9] = 1'b1;
        idle(3);
        wr(12'h08C, 32'h0000_0200);
        idle(15);
        chk_irq(1'b0, "R7");
        rd(12'h040, 32'hFFFF_FF89, "R7");
        src[9] = 1'b0;

        // R3: third bank
        wr(12'h0C8, 32'h0000_0040);
        src[70] = 1'b1;
        rd(12'h0D8, 32'h0000_0040, "R3");

        // R10: autoidle bit and soft reset
        wr(12'h010, 32'h1);
        rd(12'h010, 32'h0000_0001, "R10");
        wr(12'h010, 32'h2);
        rd(12'h014, 32'h0000_0000, "R10");
        rd(12'h014, 32'h0000_0001, "R10");
        rd(12'h010, 32'h0000_0000, "R10");
        rd(12'h0C4, 32'hFFFF_FFFF, "R10");
        rd(12'h068, 32'h0000_00FF, "R10");
        rd(12'h124, 32'h0000_0000, "R10");
        idle(15);
        chk_irq(1'b0, "R10");
        src = '0;

        idle(3);
        $display("  End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule